// File: doc/BRIEF.md
# Multi-cell overcharge protection sequencer

This block is the digital sequencer of a secondary protection device that watches a stack of two to four series cells. Analog comparators outside the block report, for every cell, whether it sits above its overcharge threshold and whether it sits below its release level, which is the threshold less the hysteresis. The block counts how long an overcharge persists, in ticks of a slow timebase strobe. When the detection delay runs out it raises and holds the active-high charge-FET gate drive `co`. That drive is let go only after a qualified release followed by a rising edge on the control pin.

Short dropouts of the over-threshold condition do not restart the detection count. Only a dropout that lasts the timer-reset delay sends the block back to idle. A test-request flag that is held long enough puts the block into a latched test mode. In that mode only the detection delay is cut to one sixty-fourth. The mode leaves by itself at the first trip, and an undervoltage lockout clears the output latch and the test mode at once.

Top module: `ovc_protect_ctrl`

## Requirements
- R1: After synchronous reset, `co`, `st_timing`, `st_over`, `st_wait` and `st_test` are all 0.
- R2: `cell_sel` picks the cells in use: 0 selects 2 cells, 1 selects 3, and 2 or 3 selects all 4 (cell i is bit i of the flag buses). An over flag on an unused cell is ignored. An unused cell counts as released whatever its release flag.
- R3: From idle, an over flag on an active cell moves the block to timing (`st_timing`=1) at the next clock. After TCU_TICKS ticks counted in timing, with some active over flag asserted, `co` and `st_over` go to 1 at the next clock. After TCU_TICKS-1 ticks `co` is still 0.
- R4: A dropout of all active over flags that lasts fewer than TTR_TICKS ticks does not restart the detection count. Ticks during the dropout still count toward TCU_TICKS.
- R5: A dropout that lasts TTR_TICKS ticks returns the block to idle. A later over flag starts the detection count from zero.
- R6: In the overcharged state, when every active release flag is 1 for TCL_TICKS consecutive ticks, the block moves to released-awaiting-control (`st_wait`=1) and `co` stays 1. Any active release flag at 0 restarts that count.
- R7: In released-awaiting-control, a 0-to-1 transition of `ctl_in` makes `co` 0 and returns the block to idle three clocks after the input changes. A level held on `ctl_in` does nothing.
- R8: A `ctl_in` rising edge seen while still overcharged (before release qualifies) is ignored and not remembered.
- R9: In released-awaiting-control, an active release flag at 0 returns the block to the overcharged state.
- R10: While `uvlo` is 1, the block is forced to idle at the next clock, with `co` 0 and `st_test` 0.
- R11: When `test_req` is 1 for TTST_TICKS consecutive ticks, `st_test` becomes 1 and stays 1 after `test_req` drops. A request that drops earlier restarts its count.
- R12: In test mode the detection delay is max(TCU_TICKS/64,1) ticks. The dropout delay TTR_TICKS and the release delay TCL_TICKS are unchanged.
- R13: Test mode ends at the clock where `co` rises at the end of a detection delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe of the slow timebase |
| cell_sel | input | 2 | Cells in use: 0=2, 1=3, 2 or 3=4 |
| cell_over | input | N_CELLS | Per-cell flag: above overcharge threshold |
| cell_below | input | N_CELLS | Per-cell flag: below threshold minus hysteresis |
| ctl_in | input | 1 | Control pin, asynchronous, low when floating |
| test_req | input | 1 | Test-mode request flag |
| uvlo | input | 1 | Undervoltage-lockout flag |
| co | output | 1 | Charge-FET gate drive, active high, latched |
| st_timing | output | 1 | Detection delay running |
| st_over | output | 1 | Overcharged, release not yet qualified |
| st_wait | output | 1 | Released, waiting for a control rising edge |
| st_test | output | 1 | Test mode latched |

## Verification
The bench sweeps every cell-select code against an over flag on each cell, and runs release with partial flag sets, so that a wrong mask would start timing from an unused cell or never qualify release. It probes dropouts one tick short of and exactly at the timer-reset delay, both in normal and in test mode. A block that reset the detection count on any dropout, or that shortened the dropout delay along with the detection delay, would trip late or leave timing early. It also raises the control input while still overcharged and holds it high across release; a design that remembered edges or cleared on level would drop `co` too early. Test-mode entry is checked one tick short of the request window, and the self-exit at the trip is checked too.

// File: rtl/ovc_pkg.sv
package ovc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TIMING  = 2'd1,
        ST_OVER    = 2'd2,
        ST_WAITCTL = 2'd3
    } prot_state_t;

    typedef struct packed {
        logic any_over;   // some active cell above its threshold
        logic all_below;  // every active cell below release level
    } cell_summary_t;

    localparam int MIN_CELLS = 2;
    localparam int TEST_DIV  = 64;

    function automatic int cells_in_use(input logic [1:0] sel, input int max_cells);
        int n;
        n = MIN_CELLS + int'(sel);
        if (n > max_cells) n = max_cells;
        return n;
    endfunction

    function automatic int test_delay(input int normal_ticks);
        int t;
        t = normal_ticks / TEST_DIV;
        if (t < 1) t = 1;
        return t;
    endfunction

endpackage

// File: rtl/ovc_cell_agg.sv
module ovc_cell_agg
    import ovc_pkg::*;
#(
    parameter int N_CELLS = 4
) (
    input  logic [1:0]         cell_sel,
    input  logic [N_CELLS-1:0] cell_over,
    input  logic [N_CELLS-1:0] cell_below,
    output logic [N_CELLS-1:0] active_mask,
    output cell_summary_t      summary
);
    int n_used;
    logic [N_CELLS-1:0] over_m;
    logic [N_CELLS-1:0] below_m;

    always_comb n_used = cells_in_use(cell_sel, N_CELLS);

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        assign active_mask[i] = (i < n_used);
        assign over_m[i]      = cell_over[i] & active_mask[i];
        assign below_m[i]     = cell_below[i] | ~active_mask[i];
    end

    always_comb begin
        summary.any_over  = |over_m;
        summary.all_below = &below_m;
    end
endmodule

// File: rtl/ovc_ctl_edge.sv
module ovc_ctl_edge (
    input  logic clk,
    input  logic rst,
    input  logic ctl_in,
    output logic ctl_rise
);
    logic s1, s2, s2_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            s2_d <= 1'b0;
        end else begin
            s1   <= ctl_in;
            s2   <= s1;
            s2_d <= s2;
        end
    end

    assign ctl_rise = s2 & ~s2_d;
endmodule

// File: rtl/ovc_test_latch.sv
module ovc_test_latch #(
    parameter int TTST_TICKS = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic test_req,
    input  logic uvlo,
    input  logic trip,
    output logic test_on
);
    localparam int TW = $clog2(TTST_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(TTST_TICKS - 1);

    logic [TW-1:0] req_cnt;

    always_ff @(posedge clk) begin
        if (rst || uvlo) begin
            test_on <= 1'b0;
            req_cnt <= '0;
        end else if (test_on) begin
            req_cnt <= '0;
            if (trip) test_on <= 1'b0;
        end else if (!test_req) begin
            req_cnt <= '0;
        end else if (tick) begin
            if (req_cnt == LAST) begin
                test_on <= 1'b1;
                req_cnt <= '0;
            end else begin
                req_cnt <= req_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ovc_seq.sv
module ovc_seq
    import ovc_pkg::*;
#(
    parameter int TCU_TICKS = 8000,
    parameter int TCL_TICKS = 120,
    parameter int TTR_TICKS = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  cell_summary_t summary,
    input  logic          test_on,
    input  logic          ctl_rise,
    input  logic          uvlo,
    output prot_state_t   state,
    output logic          co,
    output logic          trip
);
    localparam int DW = $clog2(TCU_TICKS + 1);
    localparam int GW = $clog2(TTR_TICKS + 1);
    localparam int RW = $clog2(TCL_TICKS + 1);
    localparam logic [DW-1:0] DET_NORM = DW'(TCU_TICKS);
    localparam logic [DW-1:0] DET_TEST = DW'(test_delay(TCU_TICKS));
    localparam logic [GW-1:0] GL_LAST  = GW'(TTR_TICKS - 1);
    localparam logic [RW-1:0] RL_LAST  = RW'(TCL_TICKS - 1);

    logic [DW-1:0] det_cnt;
    logic [GW-1:0] gl_cnt;
    logic [RW-1:0] rl_cnt;
    logic [DW-1:0] det_limit;

    always_comb begin
        det_limit = test_on ? DET_TEST : DET_NORM;
        trip = (state == ST_TIMING) && summary.any_over && (det_cnt >= det_limit);
    end

    always_ff @(posedge clk) begin
        if (rst || uvlo) begin
            state   <= ST_IDLE;
            co      <= 1'b0;
            det_cnt <= '0;
            gl_cnt  <= '0;
            rl_cnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    det_cnt <= '0;
                    gl_cnt  <= '0;
                    rl_cnt  <= '0;
                    if (summary.any_over) state <= ST_TIMING;
                end
                ST_TIMING: begin
                    if (trip) begin
                        state  <= ST_OVER;
                        co     <= 1'b1;
                        rl_cnt <= '0;
                    end else begin
                        if (tick && det_cnt < DET_NORM) det_cnt <= det_cnt + 1'b1;
                        if (summary.any_over) begin
                            gl_cnt <= '0;
                        end else if (tick) begin
                            if (gl_cnt == GL_LAST) state <= ST_IDLE;
                            else gl_cnt <= gl_cnt + 1'b1;
                        end
                    end
                end
                ST_OVER: begin
                    if (!summary.all_below) begin
                        rl_cnt <= '0;
                    end else if (tick) begin
                        if (rl_cnt == RL_LAST) begin
                            state  <= ST_WAITCTL;
                            rl_cnt <= '0;
                        end else begin
                            rl_cnt <= rl_cnt + 1'b1;
                        end
                    end
                end
                ST_WAITCTL: begin
                    if (!summary.all_below) begin
                        state  <= ST_OVER;
                        rl_cnt <= '0;
                    end else if (ctl_rise) begin
                        state <= ST_IDLE;
                        co    <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ovc_protect_ctrl.sv
module ovc_protect_ctrl
    import ovc_pkg::*;
#(
    parameter int N_CELLS    = 4,
    parameter bit FAST       = 1'b0,
    parameter int TCU_TICKS  = FAST ? 4000 : 8000,
    parameter int TCL_TICKS  = FAST ? 60 : 120,
    parameter int TTR_TICKS  = FAST ? 15 : 30,
    parameter int TTST_TICKS = 160
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [1:0]         cell_sel,
    input  logic [N_CELLS-1:0] cell_over,
    input  logic [N_CELLS-1:0] cell_below,
    input  logic               ctl_in,
    input  logic               test_req,
    input  logic               uvlo,
    output logic               co,
    output logic               st_timing,
    output logic               st_over,
    output logic               st_wait,
    output logic               st_test
);
    logic [N_CELLS-1:0] active_mask;
    cell_summary_t      summary;
    logic               ctl_rise;
    logic               trip;
    logic               test_on;
    prot_state_t        state;

    ovc_cell_agg #(.N_CELLS(N_CELLS)) u_agg (
        .cell_sel    (cell_sel),
        .cell_over   (cell_over),
        .cell_below  (cell_below),
        .active_mask (active_mask),
        .summary     (summary)
    );

    ovc_ctl_edge u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ctl_in   (ctl_in),
        .ctl_rise (ctl_rise)
    );

    ovc_test_latch #(.TTST_TICKS(TTST_TICKS)) u_test (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .test_req (test_req),
        .uvlo     (uvlo),
        .trip     (trip),
        .test_on  (test_on)
    );

    ovc_seq #(
        .TCU_TICKS (TCU_TICKS),
        .TCL_TICKS (TCL_TICKS),
        .TTR_TICKS (TTR_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .summary  (summary),
        .test_on  (test_on),
        .ctl_rise (ctl_rise),
        .uvlo     (uvlo),
        .state    (state),
        .co       (co),
        .trip     (trip)
    );

    assign st_timing = (state == ST_TIMING);
    assign st_over   = (state == ST_OVER);
    assign st_wait   = (state == ST_WAITCTL);
    assign st_test   = test_on;
endmodule

// File: rtl/ovc_protect_chk.sv
module ovc_protect_chk #(
    parameter int N_CELLS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               uvlo,
    input logic [N_CELLS-1:0] cell_over,
    input logic [N_CELLS-1:0] active_mask,
    input logic               co,
    input logic               st_timing,
    input logic               st_over,
    input logic               st_wait,
    input logic               st_test
);
    AST_STATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_timing, st_over, st_wait}));                              // R3

    AST_CO_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
        co == (st_over || st_wait));                                           // R6

    AST_CO_RISE_FROM_TIMING: assert property (@(posedge clk) disable iff (rst)
        $rose(co) |-> $past(st_timing));                                       // R3

    AST_CO_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(co) |-> ($past(st_wait) || $past(uvlo)));                        // R7

    AST_WAIT_FROM_OVER: assert property (@(posedge clk) disable iff (rst)
        $rose(st_wait) |-> $past(st_over));                                    // R6

    AST_UVLO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        uvlo |=> (!co && !st_test && !st_timing));                             // R10

    AST_TEST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(st_test) |-> ($past(uvlo) || $rose(co)));                        // R13

    AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!st_timing && !st_over && !st_wait && !uvlo && ((cell_over & active_mask) == '0))
        |=> !st_timing);                                                       // R2
endmodule

bind ovc_protect_ctrl ovc_protect_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .uvlo        (uvlo),
    .cell_over   (cell_over),
    .active_mask (active_mask),
    .co          (co),
    .st_timing   (st_timing),
    .st_over     (st_over),
    .st_wait     (st_wait),
    .st_test     (st_test)
);

// File: tb/tb_ovc_protect_ctrl.sv
module tb_ovc_protect_ctrl;
    localparam int NC   = 4;
    localparam int TCU  = 128;
    localparam int TCL  = 6;
    localparam int TTR  = 3;
    localparam int TTST = 5;
    localparam int TCU_T = (TCU / 64 < 1) ? 1 : TCU / 64;

    logic clk = 1'b0;
    logic rst, tick, ctl_in, test_req, uvlo;
    logic [1:0] cell_sel;
    logic [NC-1:0] cell_over, cell_below;
    logic co, st_timing, st_over, st_wait, st_test;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ovc_protect_ctrl #(
        .N_CELLS(NC), .TCU_TICKS(TCU), .TCL_TICKS(TCL),
        .TTR_TICKS(TTR), .TTST_TICKS(TTST)
    ) dut (
        .clk(clk), .rst(rst), .tick(tick), .cell_sel(cell_sel),
        .cell_over(cell_over), .cell_below(cell_below), .ctl_in(ctl_in),
        .test_req(test_req), .uvlo(uvlo), .co(co), .st_timing(st_timing),
        .st_over(st_over), .st_wait(st_wait), .st_test(st_test)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=200000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse_uvlo();
        @(negedge clk) uvlo = 1'b1;
        @(negedge clk) uvlo = 1'b0;
        @(negedge clk);
    endtask

    task automatic go_over();
        cell_below = '0;
        @(negedge clk) cell_over = 4'b0001;
        ticks(TCU);
        cell_over = '0;
    endtask

    initial begin
        rst = 1'b1; tick = 0; ctl_in = 0; test_req = 0; uvlo = 0;
        cell_sel = 2'd2; cell_over = '0; cell_below = '0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 co", co, 0);
        chk("R1 status", {st_timing, st_over, st_wait, st_test}, 0);

        // R2 mask sweep on over flags
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < NC; c++) begin
                int used;
                used = (2 + s > NC) ? NC : 2 + s;
                cell_sel = s[1:0];
                cell_over = NC'(1) << c;
                cyc(2);
                chk($sformatf("R2 sel=%0d cell=%0d timing", s, c), st_timing, (c < used) ? 1 : 0);
                cell_over = '0;
                pulse_uvlo();
            end
        end

        // R3 detection delay boundary
        cell_sel = 2'd2;
        @(negedge clk) cell_over = 4'b1000;
        cyc(1);
        chk("R3 timing entered", st_timing, 1);
        ticks(TCU - 1);
        chk("R3 co before delay", co, 0);
        ticks(1);
        chk("R3 co after delay", co, 1);
        chk("R3 st_over", st_over, 1);
        cell_over = '0;
        pulse_uvlo();
        chk("R10 co cleared", co, 0);

        // R4 short dropout keeps counting
        @(negedge clk) cell_over = 4'b0010;
        ticks(50);
        cell_over = '0;
        ticks(TTR - 1);
        chk("R4 still timing", st_timing, 1);
        cell_over = 4'b0010;
        ticks(TCU - 50 - (TTR - 1) - 1);
        chk("R4 co one tick early", co, 0);
        ticks(1);
        chk("R4 co on schedule", co, 1);
        cell_over = '0;
        pulse_uvlo();

        // R5 long dropout restarts count
        @(negedge clk) cell_over = 4'b0100;
        ticks(50);
        cell_over = '0;
        ticks(TTR);
        chk("R5 back to idle", st_timing, 0);
        cell_over = 4'b0100;
        ticks(TCU - 1);
        chk("R5 restarted count", co, 0);
        ticks(1);
        chk("R5 co after full delay", co, 1);
        cell_over = '0;
        pulse_uvlo();

        // R6 release with masked cells
        cell_sel = 2'd0;
        go_over();
        cell_below = 4'b0011;
        ticks(TCL - 1);
        chk("R6 not yet released", st_wait, 0);
        ticks(1);
        chk("R6 released 2 cells", st_wait, 1);
        chk("R6 co held", co, 1);
        pulse_uvlo();
        cell_sel = 2'd3;
        go_over();
        cell_below = 4'b0111;
        ticks(TCL + 2);
        chk("R6 cell3 blocks release", st_over, 1);
        cell_below = 4'b1111;
        ticks(3);
        cell_below = 4'b1110;
        cyc(1);
        cell_below = 4'b1111;
        ticks(TCL - 1);
        chk("R6 count restarted", st_over, 1);
        ticks(1);
        chk("R6 released 4 cells", st_wait, 1);

        // R9 release lost in wait
        cell_below = 4'b1011;
        cyc(2);
        chk("R9 back to over", st_over, 1);
        pulse_uvlo();

        // R8 edge before release ignored; R7 level does nothing, edge clears
        go_over();
        @(negedge clk) ctl_in = 1'b1;
        cyc(5);
        ctl_in = 1'b0;
        cyc(5);
        ctl_in = 1'b1;
        cyc(5);
        chk("R8 co during over", co, 1);
        cell_below = 4'b1111;
        ticks(TCL);
        cyc(10);
        chk("R8 edge not remembered", st_wait, 1);
        chk("R7 level high no clear", co, 1);
        ctl_in = 1'b0;
        cyc(5);
        chk("R7 level low no clear", co, 1);
        ctl_in = 1'b1;
        cyc(2);
        chk("R7 co before sync latency", co, 1);
        cyc(1);
        chk("R7 co cleared by edge", co, 0);
        ctl_in = 1'b0;
        cell_below = '0;
        cyc(4);

        // R11 test entry
        @(negedge clk) test_req = 1'b1;
        ticks(TTST - 1);
        test_req = 1'b0;
        ticks(1);
        test_req = 1'b1;
        ticks(TTST - 1);
        chk("R11 short request", st_test, 0);
        ticks(1);
        chk("R11 entered", st_test, 1);
        test_req = 1'b0;
        ticks(3);
        chk("R11 latched", st_test, 1);

        // R12 dropout delay unchanged in test mode
        @(negedge clk) cell_over = 4'b0001;
        ticks(1);
        cell_over = '0;
        ticks(TTR - 1);
        chk("R12 ttr not shortened", st_timing, 1);
        ticks(1);
        chk("R12 ttr expires", st_timing, 0);
        chk("R12 test kept", st_test, 1);

        // R12 shortened detection, R13 exit at trip
        @(negedge clk) cell_over = 4'b0001;
        ticks(TCU_T - 1);
        chk("R12 short delay early", co, 0);
        ticks(1);
        chk("R12 short delay trips", co, 1);
        chk("R13 test exited", st_test, 0);
        cell_over = '0;

        // R12 release delay unchanged: enter test while over
        test_req = 1'b1;
        ticks(TTST);
        test_req = 1'b0;
        chk("R11 entered while over", st_test, 1);
        cell_below = 4'b1111;
        ticks(TCL - 1);
        chk("R12 tcl not shortened", st_wait, 0);
        ticks(1);
        chk("R12 tcl full", st_wait, 1);

        // R10 uvlo clears latch and test mode
        pulse_uvlo();
        chk("R10 co", co, 0);
        chk("R10 test", st_test, 0);
        chk("R10 idle", {st_timing, st_over, st_wait}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule